// File: doc/BRIEF.md
# Bus Access Match Filter

This block snoops the accesses of five bus masters (a processor port at index 0 and four DMA ports at indices 1 to 4). For each access it decides whether the access should be logged. Logging happens only when four conditions hold. The master must be enabled. The address must lie inside that master's private address window. The access type and size must be selected by the mode bits. The access data must equal a reference word on every byte that the byte mask does not exclude.

Each master's window is a register pair. It is loaded from a shared lower and upper bound pair when a one-cycle update pulse arrives, either for that master alone or for all masters at once. When several masters qualify in the same cycle, a fixed priority picks one. The chosen access is presented one cycle later as a log request carrying the master index, address and data, under a valid/ready handshake towards the storage writer.

Top module: `access_log_filter`

## Requirements
- R1: After reset `log_valid` is 0, and every master window is empty (lower bound all ones, upper bound zero), so no access qualifies until a window is loaded.
- R2: An access from master m is never logged while `mst_en[m]` is 0.
- R3: An address qualifies when window lower ≤ address ≤ window upper, with both ends inclusive.
- R4: A 1 on `win_upd[m]` for one cycle copies `lo_bound` and `hi_bound` into master m's window only. Changes to the bound inputs without a pulse do not alter any window.
- R5: A 1 on `win_upd_all` copies the bounds into every master's window in the same cycle.
- R6: A window whose lower bound exceeds its upper bound matches no address.
- R7: With `mode[0]` set, only writes (`acc_write`=1) qualify. With it clear, both reads and writes qualify.
- R8: The size code `acc_size` is 00 for byte, 01 for halfword, 10 for word and 11 for reserved. A byte access needs `mode[3]`, a halfword access needs `mode[2]` and a word access needs `mode[1]`. A reserved code never qualifies.
- R9: Data byte k (bits 8k+7:8k) must equal the same byte of `ref_data` unless `byte_mask[k]` is 1, in which case that byte is ignored.
- R10: When several masters qualify in one cycle, the lowest index wins. Exactly one request is produced, and the other accesses of that cycle are dropped.
- R11: A qualifying access sampled at clock edge t appears on `log_valid`, `log_mst`, `log_addr` and `log_data` right after edge t.
- R12: While `log_valid`=1 and `log_ready`=0, the request is held unchanged, and accesses arriving during the stall are dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| mode | input | 4 | Bit 0 write-only, bit 1 word, bit 2 halfword, bit 3 byte |
| mst_en | input | NUM_MST | Per-master logging enable |
| lo_bound | input | 32 | Shared lower bound for window loads |
| hi_bound | input | 32 | Shared upper bound for window loads |
| win_upd | input | NUM_MST | Per-master window load pulse |
| win_upd_all | input | 1 | Load pulse for all windows |
| ref_data | input | 32 | Reference data word |
| byte_mask | input | 4 | 1 excludes the corresponding data byte from compare |
| acc_valid | input | NUM_MST | Access present, per master |
| acc_write | input | NUM_MST | Access is a write, per master |
| acc_size | input | 2*NUM_MST | Size code, 2 bits per master |
| acc_addr | input | 32*NUM_MST | Address, 32 bits per master |
| acc_data | input | 32*NUM_MST | Data, 32 bits per master |
| log_ready | input | 1 | Downstream accepts the log request |
| log_valid | output | 1 | Log request present |
| log_mst | output | MST_W | Index of the logged master |
| log_addr | output | 32 | Logged address |
| log_data | output | 32 | Logged data |

## Verification
The assertions assume that the snoop inputs are stable across each rising edge. They also assume that `mst_en`, `mode` and the size fields are meaningful in the cycle an access is sampled, because the checks relate a new request to the enable, write flag and size code seen one edge earlier. The stimulus changes every input only on falling edges, holds each access for exactly one cycle, and drives only size codes and master indices within range. Stall checks keep `log_ready` low for whole cycles, so the hold property sees a clean stall.

// File: rtl/alf_pkg.sv
package alf_pkg;
    localparam int ADDR_W = 32;
    localparam int DATA_W = 32;
    localparam int BYTES  = DATA_W / 8;

    // mode bit positions
    localparam int MODE_WR_ONLY = 0;
    localparam int MODE_WORD    = 1;
    localparam int MODE_HALF    = 2;
    localparam int MODE_BYTE    = 3;

    typedef enum logic [1:0] {
        SZ_BYTE = 2'b00,
        SZ_HALF = 2'b01,
        SZ_WORD = 2'b10,
        SZ_RSVD = 2'b11
    } acc_size_e;

    typedef struct packed {
        logic [ADDR_W-1:0] lo;
        logic [ADDR_W-1:0] hi;
    } window_t;
endpackage

// File: rtl/alf_window.sv
module alf_window
    import alf_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic [ADDR_W-1:0] lo_in,
    input  logic [ADDR_W-1:0] hi_in,
    input  logic [ADDR_W-1:0] addr,
    output logic              hit
);
    window_t win_d, win_q;

    always_comb begin
        win_d = win_q;
        if (load) begin
            win_d.lo = lo_in;
            win_d.hi = hi_in;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            win_q.lo <= '1;   // empty window after reset
            win_q.hi <= '0;
        end else begin
            win_q <= win_d;
        end
    end

    // inclusive on both ends; lo > hi can never satisfy both
    assign hit = (addr >= win_q.lo) && (addr <= win_q.hi);
endmodule

// File: rtl/alf_qualify.sv
module alf_qualify
    import alf_pkg::*;
(
    input  logic [3:0]        mode,
    input  logic              wr,
    input  logic [1:0]        size,
    input  logic [DATA_W-1:0] data,
    input  logic [DATA_W-1:0] ref_word,
    input  logic [BYTES-1:0]  mask,
    output logic              pass
);
    logic [BYTES-1:0] byte_ok;
    logic             size_ok;
    logic             type_ok;

    for (genvar g = 0; g < BYTES; g++) begin : g_byte
        assign byte_ok[g] = mask[g] | (data[g*8 +: 8] == ref_word[g*8 +: 8]);
    end

    always_comb begin
        case (acc_size_e'(size))
            SZ_BYTE: size_ok = mode[MODE_BYTE];
            SZ_HALF: size_ok = mode[MODE_HALF];
            SZ_WORD: size_ok = mode[MODE_WORD];
            default: size_ok = 1'b0;
        endcase
    end

    assign type_ok = !mode[MODE_WR_ONLY] || wr;
    assign pass    = size_ok && type_ok && (&byte_ok);
endmodule

// File: rtl/alf_pick.sv
module alf_pick #(
    parameter int N  = 5,
    parameter int IW = 3
) (
    input  logic [N-1:0]  req,
    output logic          any,
    output logic [IW-1:0] idx
);
    always_comb begin
        idx = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (req[i]) idx = IW'(i);
        end
    end

    assign any = |req;
endmodule

// File: rtl/access_log_filter.sv
module access_log_filter
    import alf_pkg::*;
#(
    parameter  int NUM_MST = 5,
    localparam int MST_W   = (NUM_MST > 1) ? $clog2(NUM_MST) : 1
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic [3:0]                mode,
    input  logic [NUM_MST-1:0]        mst_en,
    input  logic [ADDR_W-1:0]         lo_bound,
    input  logic [ADDR_W-1:0]         hi_bound,
    input  logic [NUM_MST-1:0]        win_upd,
    input  logic                      win_upd_all,
    input  logic [DATA_W-1:0]         ref_data,
    input  logic [BYTES-1:0]          byte_mask,
    input  logic [NUM_MST-1:0]        acc_valid,
    input  logic [NUM_MST-1:0]        acc_write,
    input  logic [2*NUM_MST-1:0]      acc_size,
    input  logic [ADDR_W*NUM_MST-1:0] acc_addr,
    input  logic [DATA_W*NUM_MST-1:0] acc_data,
    input  logic                      log_ready,
    output logic                      log_valid,
    output logic [MST_W-1:0]          log_mst,
    output logic [ADDR_W-1:0]         log_addr,
    output logic [DATA_W-1:0]         log_data
);
    typedef struct packed {
        logic              valid;
        logic [MST_W-1:0]  mst;
        logic [ADDR_W-1:0] addr;
        logic [DATA_W-1:0] data;
    } log_t;

    logic [NUM_MST-1:0] win_hit;
    logic [NUM_MST-1:0] qual;
    logic [NUM_MST-1:0] cand;
    logic               any_cand;
    logic [MST_W-1:0]   sel;
    log_t               out_d, out_q;

    for (genvar m = 0; m < NUM_MST; m++) begin : g_mst
        alf_window u_win (
            .clk   (clk),
            .rst_n (rst_n),
            .load  (win_upd[m] | win_upd_all),
            .lo_in (lo_bound),
            .hi_in (hi_bound),
            .addr  (acc_addr[m*ADDR_W +: ADDR_W]),
            .hit   (win_hit[m])
        );

        alf_qualify u_qual (
            .mode     (mode),
            .wr       (acc_write[m]),
            .size     (acc_size[m*2 +: 2]),
            .data     (acc_data[m*DATA_W +: DATA_W]),
            .ref_word (ref_data),
            .mask     (byte_mask),
            .pass     (qual[m])
        );

        assign cand[m] = acc_valid[m] & mst_en[m] & win_hit[m] & qual[m];
    end

    alf_pick #(.N(NUM_MST), .IW(MST_W)) u_pick (
        .req (cand),
        .any (any_cand),
        .idx (sel)
    );

    always_comb begin
        out_d = out_q;
        if (!out_q.valid || log_ready) begin
            out_d.valid = any_cand;
            if (any_cand) begin
                out_d.mst  = sel;
                out_d.addr = acc_addr[sel*ADDR_W +: ADDR_W];
                out_d.data = acc_data[sel*DATA_W +: DATA_W];
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) out_q <= '0;
        else        out_q <= out_d;
    end

    assign log_valid = out_q.valid;
    assign log_mst   = out_q.mst;
    assign log_addr  = out_q.addr;
    assign log_data  = out_q.data;
endmodule

// File: rtl/alf_checker.sv
module alf_checker
    import alf_pkg::*;
#(
    parameter  int NUM_MST = 5,
    localparam int MST_W   = (NUM_MST > 1) ? $clog2(NUM_MST) : 1
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic [3:0]           mode,
    input logic [NUM_MST-1:0]   mst_en,
    input logic [NUM_MST-1:0]   acc_valid,
    input logic [NUM_MST-1:0]   acc_write,
    input logic [2*NUM_MST-1:0] acc_size,
    input logic                 log_ready,
    input logic                 log_valid,
    input logic [MST_W-1:0]     log_mst,
    input logic [ADDR_W-1:0]    log_addr,
    input logic [DATA_W-1:0]    log_data
);
    logic fresh;
    logic stalled_q;

    always_ff @(posedge clk) begin
        if (!rst_n) stalled_q <= 1'b0;
        else        stalled_q <= log_valid && !log_ready;
    end

    assign fresh = log_valid && !stalled_q;

    AST_HOLD_STALL: assert property (@(posedge clk) disable iff (!rst_n)
        log_valid && !log_ready |=> log_valid && $stable(log_mst) && $stable(log_addr) && $stable(log_data)); // R12

    AST_MST_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
        log_valid |-> int'(log_mst) < NUM_MST); // R10

    AST_SRC_ENABLED: assert property (@(posedge clk) disable iff (!rst_n)
        fresh |-> |($past(mst_en & acc_valid) & (NUM_MST'(1) << log_mst))); // R2

    AST_WRITE_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
        fresh && $past(mode[MODE_WR_ONLY]) |-> |($past(acc_write) & (NUM_MST'(1) << log_mst))); // R7

    AST_NO_RSVD_SIZE: assert property (@(posedge clk) disable iff (!rst_n)
        fresh |-> 2'($past(acc_size) >> (2 * int'(log_mst))) != 2'b11); // R8
endmodule

bind access_log_filter alf_checker #(.NUM_MST(NUM_MST)) u_alf_checker (.*);

// File: tb/access_log_filter_bench.sv
`timescale 1ns/1ps
module access_log_filter_bench;
    localparam int N  = 5;
    localparam int MW = 3;

    logic            clk = 1'b0;
    logic            rst_n;
    logic [3:0]      mode;
    logic [N-1:0]    mst_en;
    logic [31:0]     lo_bound, hi_bound;
    logic [N-1:0]    win_upd;
    logic            win_upd_all;
    logic [31:0]     ref_data;
    logic [3:0]      byte_mask;
    logic [N-1:0]    acc_valid, acc_write;
    logic [2*N-1:0]  acc_size;
    logic [32*N-1:0] acc_addr, acc_data;
    logic            log_ready;
    logic            log_valid;
    logic [MW-1:0]   log_mst;
    logic [31:0]     log_addr, log_data;

    int n_run  = 0;
    int n_fail = 0;
    bit done   = 0;

    always #2 clk = ~clk;   // 250 MHz

    access_log_filter #(.NUM_MST(N)) u_access_log_filter (.*);

    task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
        n_run++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic drive(input int m, input bit wr, input logic [1:0] sz,
                         input logic [31:0] a, input logic [31:0] d);
        acc_valid[m]         = 1'b1;
        acc_write[m]         = wr;
        acc_size[m*2 +: 2]   = sz;
        acc_addr[m*32 +: 32] = a;
        acc_data[m*32 +: 32] = d;
    endtask

    // one access held for one cycle, output checked after the capturing edge
    task automatic access(input int m, input bit wr, input logic [1:0] sz,
                          input logic [31:0] a, input logic [31:0] d,
                          input bit exp_v, input string tag);
        @(negedge clk);
        drive(m, wr, sz, a, d);
        @(negedge clk);
        acc_valid = '0;
        chk(log_valid == exp_v, tag, log_valid, exp_v);
        if (exp_v && log_valid) begin
            chk(int'(log_mst) == m, tag, log_mst, m);
            chk(log_addr == a, tag, log_addr, a);
            chk(log_data == d, tag, log_data, d);
        end
    endtask

    task automatic load(input int m, input logic [31:0] lo, input logic [31:0] hi);
        @(negedge clk);
        lo_bound = lo;
        hi_bound = hi;
        if (m < 0) win_upd_all = 1'b1;
        else       win_upd[m]  = 1'b1;
        @(negedge clk);
        win_upd     = '0;
        win_upd_all = 1'b0;
    endtask

    task automatic t_reset();
        chk(log_valid == 1'b0, "R1 valid after reset", log_valid, 0);
        access(0, 1'b1, 2'b10, 32'h0, 32'h0, 1'b0, "R1 empty window addr 0");
        access(3, 1'b1, 2'b10, 32'hFFFF_FFFF, 32'h0, 1'b0, "R1 empty window addr max");
    endtask

    task automatic t_window();
        load(1, 32'h1000, 32'h1FFF);
        access(1, 1'b0, 2'b10, 32'h1000, 32'h11, 1'b1, "R3 low edge");
        access(1, 1'b1, 2'b10, 32'h1FFF, 32'h22, 1'b1, "R3 high edge");
        access(1, 1'b1, 2'b10, 32'h0FFF, 32'h33, 1'b0, "R3 below");
        access(1, 1'b1, 2'b10, 32'h2000, 32'h44, 1'b0, "R3 above");
        access(2, 1'b1, 2'b10, 32'h1000, 32'h55, 1'b0, "R4 other master untouched");
        @(negedge clk);
        lo_bound = 32'h0; hi_bound = 32'hFFFF_FFFF;
        access(1, 1'b1, 2'b10, 32'h2000, 32'h66, 1'b0, "R4 bounds change without pulse");
        access(1, 1'b1, 2'b10, 32'h1800, 32'h77, 1'b1, "R4 window kept");
    endtask

    task automatic t_all();
        load(-1, 32'h4000, 32'h40FF);
        for (int m = 0; m < N; m++)
            access(m, 1'b1, 2'b10, 32'h4000 + 32'(m*4), 32'hA0 + 32'(m), 1'b1, "R5 all-update");
        access(1, 1'b1, 2'b10, 32'h1000, 32'h1, 1'b0, "R5 old window replaced");
    endtask

    task automatic t_enable();
        @(negedge clk); mst_en[2] = 1'b0;
        access(2, 1'b1, 2'b10, 32'h4010, 32'h5, 1'b0, "R2 disabled master");
        @(negedge clk); mst_en[2] = 1'b1;
        access(2, 1'b1, 2'b10, 32'h4010, 32'h5, 1'b1, "R2 re-enabled master");
    endtask

    task automatic t_mode();
        @(negedge clk); mode = 4'b1111;
        access(0, 1'b0, 2'b10, 32'h4000, 32'h1, 1'b0, "R7 read blocked");
        access(0, 1'b1, 2'b10, 32'h4000, 32'h2, 1'b1, "R7 write passes");
        @(negedge clk); mode = 4'b0010;
        access(0, 1'b0, 2'b00, 32'h4000, 32'h3, 1'b0, "R8 byte blocked");
        access(0, 1'b0, 2'b10, 32'h4000, 32'h4, 1'b1, "R8 word passes");
        @(negedge clk); mode = 4'b0100;
        access(4, 1'b0, 2'b01, 32'h4002, 32'h5, 1'b1, "R8 half passes");
        access(4, 1'b0, 2'b10, 32'h4004, 32'h6, 1'b0, "R8 word blocked");
        @(negedge clk); mode = 4'b1000;
        access(3, 1'b0, 2'b00, 32'h4001, 32'h7, 1'b1, "R8 byte passes");
        @(negedge clk); mode = 4'b1110;
        access(3, 1'b1, 2'b11, 32'h4001, 32'h8, 1'b0, "R8 reserved size");
    endtask

    task automatic t_data();
        @(negedge clk); ref_data = 32'hA5A5_1234; byte_mask = 4'b0000;
        access(1, 1'b1, 2'b10, 32'h4000, 32'hA5A5_1234, 1'b1, "R9 exact match");
        access(1, 1'b1, 2'b10, 32'h4000, 32'h00A5_1234, 1'b0, "R9 top byte differs");
        @(negedge clk); byte_mask = 4'b1000;
        access(1, 1'b1, 2'b10, 32'h4000, 32'h00A5_1234, 1'b1, "R9 top byte masked");
        @(negedge clk); byte_mask = 4'b0001;
        access(1, 1'b1, 2'b10, 32'h4000, 32'hA5A5_12FF, 1'b1, "R9 low byte masked");
        access(1, 1'b1, 2'b10, 32'h4000, 32'hA5A5_02FF, 1'b0, "R9 byte 1 differs");
        @(negedge clk); byte_mask = 4'hF;
    endtask

    task automatic t_inverted();
        load(2, 32'h5000, 32'h4FFF);
        access(2, 1'b1, 2'b10, 32'h5000, 32'h1, 1'b0, "R6 inverted at lo");
        access(2, 1'b1, 2'b10, 32'h4FFF, 32'h2, 1'b0, "R6 inverted at hi");
        load(2, 32'h4000, 32'h40FF);
    endtask

    task automatic t_priority();
        @(negedge clk);
        for (int m = 0; m < N; m++) drive(m, 1'b1, 2'b10, 32'h4000 + 32'(m*8), 32'hB0 + 32'(m));
        @(negedge clk);
        acc_valid = '0;
        chk(log_valid && log_mst == 0, "R10 cpu wins", log_mst, 0);
        chk(log_addr == 32'h4000, "R11 winner address", log_addr, 32'h4000);
        @(negedge clk);
        chk(log_valid == 1'b0, "R10 losers dropped", log_valid, 0);
        mst_en[0] = 1'b0;
        for (int m = 0; m < N; m++) drive(m, 1'b1, 2'b10, 32'h4000 + 32'(m*8), 32'hB0 + 32'(m));
        @(negedge clk);
        acc_valid = '0;
        chk(log_valid && log_mst == 1, "R10 dma0 next", log_mst, 1);
        chk(log_data == 32'hB1, "R11 winner data", log_data, 32'hB1);
        mst_en[0] = 1'b1;
    endtask

    task automatic t_stall();
        @(negedge clk);
        log_ready = 1'b0;
        drive(3, 1'b1, 2'b10, 32'h4030, 32'hC3);
        @(negedge clk);
        acc_valid = '0;
        drive(1, 1'b1, 2'b10, 32'h4010, 32'hC1);
        @(negedge clk);
        acc_valid = '0;
        chk(log_valid && log_mst == 3, "R12 held master", log_mst, 3);
        chk(log_data == 32'hC3, "R12 held data", log_data, 32'hC3);
        log_ready = 1'b1;
        @(negedge clk);
        chk(log_valid == 1'b0, "R12 stalled access dropped", log_valid, 0);
    endtask

    initial begin
        rst_n = 1'b0; mode = 4'b1110; mst_en = '1;
        lo_bound = '0; hi_bound = '0; win_upd = '0; win_upd_all = 1'b0;
        ref_data = '0; byte_mask = 4'hF;
        acc_valid = '0; acc_write = '0; acc_size = '0; acc_addr = '0; acc_data = '0;
        log_ready = 1'b1;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_window();
        t_all();
        t_enable();
        t_mode();
        t_data();
        t_inverted();
        t_priority();
        t_stall();
        done = 1;
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_run++;
            n_fail++;
            $display("FAIL watchdog all-requirements actual=hung expected=finished");
            $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end
endmodule